// File: doc/BRIEF.md
# Ping-Pong Dual-Buffer Capture Controller

This block takes a stream of samples and stores it in two buffers that swap roles. Samples fill one buffer while a downstream consumer empties the other through a valid/ready read port. When the buffer being filled has taken its last sample, it is handed to the drain side and filling moves on to the other buffer. If that other buffer has already been emptied, the move happens with no gap. If it is still being emptied, capture pauses: a stall flag is raised and samples that arrive during the pause are dropped. The pause ends when the consumer accepts the last word of that buffer.

Both buffers sit on one clock. The drain side reads a buffer strictly in the order it was written. A buffer becomes writable again only after its final word has been taken downstream. Two tag outputs show which buffer is filling and which is draining.

Top module: `pingpong_capture`

## Requirements
- R1: While reset is held, `rdValid`, `fillTag`, `drainTag` and `overrunStall` are all 0.
- R2: Accepted samples go to buffer 0 for the first DEPTH samples after reset, then to buffer 1 for the next DEPTH, and so on in alternation. `fillTag` gives the index (0 or 1) of the buffer that will take the next accepted sample.
- R3: `rdValid` rises in the cycle after the edge that writes a buffer's last sample. It is low whenever no buffer is completely written and waiting to be drained.
- R4: Words leave on `rdData` in exactly the order they were accepted, and each buffer holds DEPTH words.
- R5: `drainTag` gives the index of the buffer being drained. It changes only on the edge where the last word of that buffer is accepted (`rdValid` and `rdReady` both high).
- R6: When a buffer fills and the other buffer is already empty, the very next sample is accepted and `overrunStall` stays low.
- R7: When a buffer fills and the other buffer still holds words, `overrunStall` is high from the next cycle until the edge where that buffer's last word is accepted. Samples offered while it is high are not stored.
- R8: While `rdValid` is high and `rdReady` is low, `rdData` and `drainTag` hold their values and `rdValid` stays high.
- R9: A cycle with `sampleValid` low stores nothing and does not advance the fill position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleValid | input | 1 | A sample is offered this cycle |
| sampleData | input | DATA_W | Sample value |
| rdValid | output | 1 | A word is available on `rdData` |
| rdReady | input | 1 | The consumer accepts the word this cycle |
| rdData | output | DATA_W | Oldest word not yet drained |
| drainTag | output | 1 | Index of the buffer being drained |
| fillTag | output | 1 | Index of the buffer being filled |
| overrunStall | output | 1 | Capture is paused and samples are dropped |

## Verification
The buffers are configured four words deep. The bench sweeps a grid of sample-arrival rates against consumer-acceptance rates. A fast consumer exercises the seamless swap, where neither buffer ever blocks the other. A slow consumer forces repeated stalls, and the data compare then shows whether dropped samples stayed out of the stream. Sparse sample input shows that idle cycles do not advance the fill position. Stretches with the consumer held back test that the output holds steady. A block-boundary count kept in the bench predicts every tag, flag and data word in every cycle.

// File: rtl/pingpong_capture_pkg.sv
`timescale 1ns/1ps
package pingpong_capture_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic wrEn;   // store sampleData this cycle
    logic wrBuf;  // buffer receiving the write
    logic rdBuf;  // buffer presented on the read port
  } strobes_t;
endpackage

// File: rtl/pingpong_capture_ctrl.sv
`timescale 1ns/1ps
module pingpong_capture_ctrl #(
  parameter int DEPTH = 1024
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          sampleValid,
  input  logic                          rdReady,
  output pingpong_capture_pkg::strobes_t strb,
  output logic [$clog2(DEPTH)-1:0]      wrAddr,
  output logic [$clog2(DEPTH)-1:0]      rdAddr,
  output logic                          rdValid,
  output logic                          fillTag,
  output logic                          drainTag,
  output logic                          overrunStall
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [1:0]    pending, pendingNext;   // buffer full and awaiting drain
  logic          fillSel, drainSel;
  logic [AW-1:0] wrPtr, rdPtr;
  logic          wrFire, rdFire, wrDone, rdDone;

  // a buffer still holding data cannot be refilled
  assign overrunStall = pending[fillSel];
  assign rdValid      = pending[drainSel];
  assign wrFire       = sampleValid && !overrunStall;
  assign rdFire       = rdValid && rdReady;
  assign wrDone       = wrFire && (wrPtr == LAST);
  assign rdDone       = rdFire && (rdPtr == LAST);

  always_comb begin
    pendingNext = pending;
    if (wrDone) pendingNext[fillSel]  = 1'b1;
    if (rdDone) pendingNext[drainSel] = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending  <= '0;
      fillSel  <= 1'b0;
      drainSel <= 1'b0;
      wrPtr    <= '0;
      rdPtr    <= '0;
    end else begin
      pending <= pendingNext;
      if (wrFire) begin
        wrPtr <= wrDone ? '0 : wrPtr + 1'b1;
        if (wrDone) fillSel <= ~fillSel;
      end
      if (rdFire) begin
        rdPtr <= rdDone ? '0 : rdPtr + 1'b1;
        if (rdDone) drainSel <= ~drainSel;
      end
    end
  end

  assign strb.wrEn  = wrFire;
  assign strb.wrBuf = fillSel;
  assign strb.rdBuf = drainSel;
  assign wrAddr     = wrPtr;
  assign rdAddr     = rdPtr;
  assign fillTag    = fillSel;
  assign drainTag   = drainSel;
endmodule

// File: rtl/pingpong_capture_dp.sv
`timescale 1ns/1ps
module pingpong_capture_dp #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 1024
) (
  input  logic                          clk,
  input  pingpong_capture_pkg::strobes_t strb,
  input  logic [$clog2(DEPTH)-1:0]      wrAddr,
  input  logic [$clog2(DEPTH)-1:0]      rdAddr,
  input  logic [DATA_W-1:0]             sampleData,
  output logic [DATA_W-1:0]             rdData
);
  localparam int NBUF = 2;

  logic [DATA_W-1:0] bufWord [NBUF];

  for (genvar b = 0; b < NBUF; b++) begin : g_buf
    logic [DATA_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (strb.wrEn && (strb.wrBuf == 1'(b)))
        mem[wrAddr] <= sampleData;
    end
    assign bufWord[b] = mem[rdAddr];
  end

  assign rdData = bufWord[strb.rdBuf];
endmodule

// File: rtl/pingpong_capture.sv
`timescale 1ns/1ps
module pingpong_capture #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 1024   // power of two, at least 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic [DATA_W-1:0] sampleData,
  output logic              rdValid,
  input  logic              rdReady,
  output logic [DATA_W-1:0] rdData,
  output logic              drainTag,
  output logic              fillTag,
  output logic              overrunStall
);
  localparam int AW = $clog2(DEPTH);

  pingpong_capture_pkg::strobes_t strb;
  logic [AW-1:0] wrAddr, rdAddr;

  pingpong_capture_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .rdReady(rdReady),
    .strb(strb), .wrAddr(wrAddr), .rdAddr(rdAddr), .rdValid(rdValid),
    .fillTag(fillTag), .drainTag(drainTag), .overrunStall(overrunStall)
  );

  pingpong_capture_dp #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .strb(strb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .sampleData(sampleData), .rdData(rdData)
  );
endmodule

// File: rtl/pingpong_capture_checker.sv
`timescale 1ns/1ps
module pingpong_capture_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              sampleValid,
  input logic              rdValid,
  input logic              rdReady,
  input logic [DATA_W-1:0] rdData,
  input logic              drainTag,
  input logic              fillTag,
  input logic              overrunStall
);
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !rdReady) |=> (rdValid && $stable(rdData) && $stable(drainTag)));

  assert_drain_swap_R5: assert property (@(posedge clk) disable iff (!rstN)
    (drainTag != $past(drainTag)) |-> $past(rdValid && rdReady));

  assert_fill_swap_R2: assert property (@(posedge clk) disable iff (!rstN)
    (fillTag != $past(fillTag)) |-> $past(sampleValid && !overrunStall));

  assert_stall_has_data_R7: assert property (@(posedge clk) disable iff (!rstN)
    overrunStall |-> rdValid);

  assert_ready_after_fill_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdValid) |-> $past(sampleValid && !overrunStall));
endmodule

bind pingpong_capture pingpong_capture_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .rdValid(rdValid),
  .rdReady(rdReady), .rdData(rdData), .drainTag(drainTag), .fillTag(fillTag),
  .overrunStall(overrunStall)
);

// File: tb/pingpong_capture_test.sv
`timescale 1ns/1ps
module pingpong_capture_test;
  localparam int DW = 8;
  localparam int DP = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rstN = 1'b0;
  logic          sampleValid = 1'b0;
  logic [DW-1:0] sampleData = '0;
  logic          rdReady = 1'b0;
  logic          rdValid, drainTag, fillTag, overrunStall;
  logic [DW-1:0] rdData;

  pingpong_capture #(.DATA_W(DW), .DEPTH(DP)) uut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleData(sampleData),
    .rdValid(rdValid), .rdReady(rdReady), .rdData(rdData),
    .drainTag(drainTag), .fillTag(fillTag), .overrunStall(overrunStall)
  );

  int vectors = 0;
  int fails   = 0;
  int writes  = 0;   // samples the requirements say are stored
  int reads   = 0;   // words accepted downstream
  int cyc     = 0;
  logic [DW-1:0] hist [4096];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (writes=%0d reads=%0d)", req, act, exp, writes, reads);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; sampleValid = 1'b0; rdReady = 1'b0;
    repeat (2) @(negedge clk);
    check(rdValid == 1'b0,      "R1 rdValid",      int'(rdValid), 0);
    check(fillTag == 1'b0,      "R1 fillTag",      int'(fillTag), 0);
    check(drainTag == 1'b0,     "R1 drainTag",     int'(drainTag), 0);
    check(overrunStall == 1'b0, "R1 overrunStall", int'(overrunStall), 0);
    rstN = 1'b1;
    writes = 0; reads = 0;
  endtask

  // one cycle: drive at negedge, compare 1 ns later, update model after posedge
  task automatic step(input bit v, input bit r);
    bit expValid, expStall, wr, rd;
    @(negedge clk);
    cyc++;
    sampleValid = v;
    sampleData  = DW'(cyc * 37 + 11);
    rdReady     = r;
    #1;
    expValid = reads < (writes / DP) * DP;
    expStall = (writes % DP == 0) && (reads + DP < writes);
    check(rdValid == expValid, "R3/R9 rdValid", int'(rdValid), int'(expValid));
    if (writes % DP == 0 && writes > 0)
      check(overrunStall == expStall, expStall ? "R7 stall" : "R6 stall", int'(overrunStall), int'(expStall));
    else
      check(overrunStall == expStall, "R7 stall", int'(overrunStall), int'(expStall));
    check(fillTag == 1'((writes / DP) % 2), "R2 fillTag", int'(fillTag), (writes / DP) % 2);
    check(drainTag == 1'((reads / DP) % 2), "R5 drainTag", int'(drainTag), (reads / DP) % 2);
    if (expValid)
      check(rdData == hist[reads], r ? "R4 rdData" : "R4/R8 rdData", int'(rdData), int'(hist[reads]));
    wr = v && !expStall;
    rd = expValid && r;
    if (wr) hist[writes] = sampleData;
    @(posedge clk);
    if (wr) writes++;
    if (rd) reads++;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    // sweep producer rate against consumer rate
    for (int vp = 1; vp <= 3; vp++) begin
      for (int rp = 1; rp <= 6; rp++) begin
        doReset();
        for (int c = 0; c < 240; c++)
          step((c % vp) == 0, (c % rp) == (rp - 1));
      end
    end
    // consumer blocked for a long stretch, then released (R7, R8)
    doReset();
    for (int c = 0; c < 40; c++) step(1'b1, 1'b0);
    for (int c = 0; c < 40; c++) step(1'b1, 1'b1);
    // sparse input with idle gaps, consumer always ready (R9, R6)
    doReset();
    for (int c = 0; c < 60; c++) step((c % 5) < 2, 1'b1);
    for (int c = 0; c < 10; c++) step(1'b0, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule